// File: doc/BRIEF.md
# Dual-Mode Logic Capture Engine

This block records a parallel bus of probe channels into an on-chip circular sample buffer. Each sample stores every channel as one bit, and all channels taken at the same instant form one stored word. Acquisition runs in one of two modes. In timing mode an internal programmable divider paces the samples. In state mode a sample is taken only on the selected edge of a clock that comes from the circuit under test. That clock passes through a two-flop synchroniser, and its edges are found in the system clock domain.

A trigger unit decides where the capture is anchored. It compares each sample with a reference word in which chosen bits can be marked as don't-care, or it follows a synchronised external trigger line. Once armed, the buffer keeps writing in a ring. When the trigger sample is stored, its address is latched. A programmable number of further samples is then written, capture stops and a done flag rises. Per-entry valid flags tell entries written since arming apart from stale ones. A combinational readout port then exposes any address, so each entry's distance from the trigger can be recovered.

Top module: `lcap_engine`

## Requirements
- R1: One sample stores all CH_W probe bits as one word at one buffer address. The write address starts at 0 after arming and steps by one per sample, wrapping modulo 2^AW.
- R2: With `mode_state`=0, sample k (counting from 0) after arming is written on system clock edge (rate_div+1)*k + rate_div + 1 counted from the arming edge, so one sample is stored every rate_div+1 clocks.
- R3: With `mode_state`=1, exactly one sample is stored per active edge of `ext_clk_in`: the rising edge when `edge_fall`=0, the falling edge when `edge_fall`=1. Nothing is stored between active edges. Each level of `ext_clk_in` must be held for at least two system clocks.
- R4: With `trig_ext_sel`=0, the trigger sample is the first sample after arming for which every bit with `trig_dc` bit = 0 equals the matching bit of `trig_word`. A `trig_dc` bit = 1 marks that bit as don't-care.
- R5: With `trig_ext_sel`=1, `trig_word` has no effect. The first sample taken after a synchronised rising edge of `ext_trig_in` is seen while armed becomes the trigger sample.
- R6: After the trigger sample, exactly `post_len` further samples are written (0 to 2^AW-1). Then `done` goes to 1 and the buffer no longer changes until the next arm.
- R7: `trig_addr` holds the buffer address of the trigger sample. `rd_data` and `rd_valid` show the word and valid flag at `rd_addr` in the same cycle.
- R8: A one-cycle `arm` pulse clears `done` and all valid flags, sets the write address to 0 and restarts the divider. Entries not written since then read `rd_valid`=0.
- R9: After reset, `done`=0, `trig_addr`=0 and every address reads `rd_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| probe_in | input | CH_W | Probe channel bus |
| ext_clk_in | input | 1 | Clock from the circuit under test (state mode) |
| ext_trig_in | input | 1 | External trigger line |
| arm | input | 1 | One-cycle pulse that starts a new capture |
| mode_state | input | 1 | 0 = divider-paced timing mode, 1 = external-edge state mode |
| edge_fall | input | 1 | State mode edge select: 0 rising, 1 falling |
| trig_ext_sel | input | 1 | 0 = word-match trigger, 1 = external trigger |
| rate_div | input | DIV_W | Timing mode divide value N (period N+1 clocks) |
| trig_word | input | CH_W | Trigger reference word |
| trig_dc | input | CH_W | Don't-care mask for the comparison (1 = ignore bit) |
| post_len | input | AW | Number of samples stored after the trigger |
| rd_addr | input | AW | Readout address |
| rd_data | output | CH_W | Stored word at rd_addr |
| rd_valid | output | 1 | Entry at rd_addr was written since arming |
| trig_addr | output | AW | Buffer address of the trigger sample |
| done | output | 1 | Capture complete |

## Verification
In timing mode the k-th sample lands on edge (N+1)k+N+1 after the arming edge. The bench clears its free-running probe counter in step with that edge, so the stored value of entry k is (N+1)k+N and each expected word follows from arithmetic. In state mode a synchronised edge reaches the buffer three system clocks after the pin toggles. The bench changes the probe bus only at the inactive edge and holds every level for five clocks, so each stored state is one known value of the sequence 7i+3. All buffer contents are read only after `done` is seen, one nanosecond after the address is set at a falling clock edge. The frozen-buffer check is repeated forty clocks later.

// File: rtl/lcap_pkg.sv
package lcap_pkg;

    // Capture controller phases
    typedef enum logic [1:0] {
        CAP_IDLE = 2'd0,
        CAP_PRE  = 2'd1,
        CAP_POST = 2'd2,
        CAP_DONE = 2'd3
    } cap_state_e;

    // Widest channel bus the comparison helper accepts
    localparam int unsigned CMP_W = 64;

    // Per-cycle acquisition event carried from pacing/trigger into the store
    typedef struct packed {
        logic strobe;
        logic hit;
    } acq_evt_t;

    // Masked equality: bits with dc=1 never cause a mismatch
    function automatic logic masked_eq(input logic [CMP_W-1:0] a,
                                       input logic [CMP_W-1:0] b,
                                       input logic [CMP_W-1:0] dc);
        return ((a ^ b) & ~dc) == '0;
    endfunction

    // Pick one edge of a synchronised signal
    function automatic logic edge_pick(input logic use_fall,
                                       input logic rise,
                                       input logic fall);
        return use_fall ? fall : rise;
    endfunction

endpackage

// File: rtl/lcap_sync.sv
module lcap_sync (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic use_fall,
    output logic edge_hit
);
    import lcap_pkg::*;

    // sh[0], sh[1]: two-flop synchroniser; sh[2]: previous synchronised level
    logic [2:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[1:0], din};
    end

    assign edge_hit = edge_pick(use_fall, sh[1] & ~sh[2], ~sh[1] & sh[2]);

    // R3: a detected edge never repeats on the next cycle
    a_r3_edge_gap: assert property (@(posedge clk) disable iff (rst)
        (edge_hit && !use_fall && sh[1]) |=> !edge_hit);

endmodule

// File: rtl/lcap_pace.sv
module lcap_pace #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             state_mode,
    input  logic             ext_edge,
    input  logic [DIV_W-1:0] div,
    output logic             strobe
);
    logic [DIV_W-1:0] cnt;
    logic             tick;

    // >= keeps the divider from running away if div is lowered mid-count
    assign tick = (cnt >= div);

    always_ff @(posedge clk) begin
        if (rst || restart) cnt <= '0;
        else if (tick)      cnt <= '0;
        else                cnt <= cnt + DIV_W'(1);
    end

    assign strobe = state_mode ? ext_edge : tick;

    // R2: with a non-zero divide value two ticks are never adjacent
    a_r2_tick_gap: assert property (@(posedge clk) disable iff (rst)
        (tick && div != '0 && !restart) |=> !tick);

endmodule

// File: rtl/lcap_trig.sv
module lcap_trig #(
    parameter int CH_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            arm,
    input  logic            listen,
    input  logic            use_ext,
    input  logic            ext_edge,
    input  logic [CH_W-1:0] sample,
    input  logic [CH_W-1:0] ref_word,
    input  logic [CH_W-1:0] dc_mask,
    output logic            hit
);
    import lcap_pkg::*;

    logic pend;   // external edge seen while armed, waiting for a sample

    always_ff @(posedge clk) begin
        if (rst || arm)                          pend <= 1'b0;
        else if (listen && use_ext && ext_edge)  pend <= 1'b1;
    end

    always_comb begin
        if (use_ext) hit = pend | ext_edge;
        else         hit = masked_eq(CMP_W'(sample), CMP_W'(ref_word), CMP_W'(dc_mask));
    end

    // R5: a pending external event survives until the next arm
    a_r5_pend_sticky: assert property (@(posedge clk) disable iff (rst)
        (pend && !arm) |=> pend);

endmodule

// File: rtl/lcap_store.sv
module lcap_store #(
    parameter int CH_W = 8,
    parameter int AW   = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            arm,
    input  lcap_pkg::acq_evt_t ev,
    input  logic [CH_W-1:0] sample,
    input  logic [AW-1:0]   post_len,
    input  logic [AW-1:0]   rd_addr,
    output logic [CH_W-1:0] rd_data,
    output logic            rd_valid,
    output logic [AW-1:0]   trig_addr,
    output logic            done,
    output logic            listen
);
    import lcap_pkg::*;

    localparam int DEPTH = 1 << AW;

    cap_state_e      st;
    logic [AW-1:0]   wptr;
    logic [AW-1:0]   left;
    logic [DEPTH-1:0] vld;
    logic [CH_W-1:0] mem [DEPTH];
    logic            wr_en;

    assign wr_en  = ev.strobe && (st == CAP_PRE || st == CAP_POST);
    assign listen = (st == CAP_PRE);
    assign done   = (st == CAP_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= CAP_IDLE;
            wptr      <= '0;
            left      <= '0;
            vld       <= '0;
            trig_addr <= '0;
        end else if (arm) begin
            st   <= CAP_PRE;
            wptr <= '0;
            left <= '0;
            vld  <= '0;
        end else if (wr_en) begin
            vld[wptr] <= 1'b1;
            wptr      <= wptr + AW'(1);
            if (st == CAP_PRE) begin
                if (ev.hit) begin
                    trig_addr <= wptr;
                    left      <= post_len;
                    st        <= (post_len == '0) ? CAP_DONE : CAP_POST;
                end
            end else begin
                left <= left - AW'(1);
                if (left == AW'(1)) st <= CAP_DONE;
            end
        end
    end

    // Sample storage: no reset, validity is tracked in vld
    always_ff @(posedge clk) begin
        if (!rst && !arm && wr_en) mem[wptr] <= sample;
    end

    assign rd_data  = mem[rd_addr];
    assign rd_valid = vld[rd_addr];

    // R1: each stored sample advances the write address by one
    a_r1_wptr_step: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !arm) |=> (wptr == $past(wptr) + AW'(1)));

    // R6: once complete the buffer is frozen until re-armed
    a_r6_frozen: assert property (@(posedge clk) disable iff (rst)
        (done && !arm) |=> (done && $stable(wptr) && $stable(vld)));

    // R7: the trigger address only moves while looking for a trigger
    a_r7_trig_hold: assert property (@(posedge clk) disable iff (rst)
        (st != CAP_PRE) |=> $stable(trig_addr));

    // R8: arming empties the buffer bookkeeping
    a_r8_arm_clear: assert property (@(posedge clk) disable iff (rst)
        arm |=> (vld == '0 && wptr == '0 && !done));

endmodule

// File: rtl/lcap_engine.sv
module lcap_engine #(
    parameter int CH_W  = 8,
    parameter int AW    = 4,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CH_W-1:0]  probe_in,
    input  logic             ext_clk_in,
    input  logic             ext_trig_in,
    input  logic             arm,
    input  logic             mode_state,
    input  logic             edge_fall,
    input  logic             trig_ext_sel,
    input  logic [DIV_W-1:0] rate_div,
    input  logic [CH_W-1:0]  trig_word,
    input  logic [CH_W-1:0]  trig_dc,
    input  logic [AW-1:0]    post_len,
    input  logic [AW-1:0]    rd_addr,
    output logic [CH_W-1:0]  rd_data,
    output logic             rd_valid,
    output logic [AW-1:0]    trig_addr,
    output logic             done
);
    import lcap_pkg::*;

    logic     clk_edge;
    logic     trg_edge;
    logic     listen;
    acq_evt_t ev;

    lcap_sync u_clk_sync (
        .clk      (clk),
        .rst      (rst),
        .din      (ext_clk_in),
        .use_fall (edge_fall),
        .edge_hit (clk_edge)
    );

    lcap_sync u_trg_sync (
        .clk      (clk),
        .rst      (rst),
        .din      (ext_trig_in),
        .use_fall (1'b0),
        .edge_hit (trg_edge)
    );

    lcap_pace #(.DIV_W(DIV_W)) u_pace (
        .clk        (clk),
        .rst        (rst),
        .restart    (arm),
        .state_mode (mode_state),
        .ext_edge   (clk_edge),
        .div        (rate_div),
        .strobe     (ev.strobe)
    );

    lcap_trig #(.CH_W(CH_W)) u_trig (
        .clk      (clk),
        .rst      (rst),
        .arm      (arm),
        .listen   (listen),
        .use_ext  (trig_ext_sel),
        .ext_edge (trg_edge),
        .sample   (probe_in),
        .ref_word (trig_word),
        .dc_mask  (trig_dc),
        .hit      (ev.hit)
    );

    lcap_store #(.CH_W(CH_W), .AW(AW)) u_store (
        .clk       (clk),
        .rst       (rst),
        .arm       (arm),
        .ev        (ev),
        .sample    (probe_in),
        .post_len  (post_len),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .trig_addr (trig_addr),
        .done      (done),
        .listen    (listen)
    );

endmodule

// File: tb/sim_lcap_engine.sv
`timescale 1ns/1ps
module sim_lcap_engine;
    localparam int CH_W  = 8;
    localparam int AW    = 4;
    localparam int DIV_W = 4;
    localparam int DEPTH = 16;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic             rst = 1'b1;
    logic [CH_W-1:0]  probe_in;
    logic             ext_clk_in = 1'b0;
    logic             ext_trig_in = 1'b0;
    logic             arm = 1'b0;
    logic             mode_state = 1'b0;
    logic             edge_fall = 1'b0;
    logic             trig_ext_sel = 1'b0;
    logic [DIV_W-1:0] rate_div = '0;
    logic [CH_W-1:0]  trig_word = '0;
    logic [CH_W-1:0]  trig_dc = '0;
    logic [AW-1:0]    post_len = '0;
    logic [AW-1:0]    rd_addr = '0;
    logic [CH_W-1:0]  rd_data;
    logic             rd_valid;
    logic [AW-1:0]    trig_addr;
    logic             done;

    logic [7:0] cnt_val = 8'd0;
    logic [7:0] st_val = 8'd0;
    logic       use_cnt = 1'b1;
    logic       cnt_clr = 1'b0;
    assign probe_in = use_cnt ? cnt_val : st_val;

    lcap_engine #(.CH_W(CH_W), .AW(AW), .DIV_W(DIV_W)) u0 (
        .clk(clk), .rst(rst), .probe_in(probe_in), .ext_clk_in(ext_clk_in),
        .ext_trig_in(ext_trig_in), .arm(arm), .mode_state(mode_state),
        .edge_fall(edge_fall), .trig_ext_sel(trig_ext_sel), .rate_div(rate_div),
        .trig_word(trig_word), .trig_dc(trig_dc), .post_len(post_len),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
        .trig_addr(trig_addr), .done(done)
    );

    // Free-running probe pattern, updated 2 ns after each rising edge
    always begin
        @(posedge clk);
        #2;
        if (cnt_clr) cnt_val = 8'd0;
        else         cnt_val = cnt_val + 8'd1;
    end

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            bad++;
            $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic read_at(input int a, output int d, output int v);
        rd_addr = AW'(a);
        #1;
        d = int'(rd_data);
        v = int'(rd_valid);
    endtask

    task automatic do_arm();
        @(negedge clk);
        arm = 1'b1;
        cnt_clr = 1'b1;
        @(negedge clk);
        arm = 1'b0;
        cnt_clr = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check(req, int'(done), 1);
    endtask

    // Signed distance of address a from the trigger address, post-window aware
    function automatic int rel_of(input int a, input int ta, input int post);
        int r = (a - ta + DEPTH) % DEPTH;
        if (r > post) r -= DEPTH;
        return r;
    endfunction

    // Drive the target clock; probe changes at the inactive edge
    task automatic run_ext(input logic fall, input int n, input int trig_i);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ext_clk_in  = fall;
            st_val      = 8'((7 * i + 3) & 255);
            ext_trig_in = (i == trig_i);
            repeat (5) @(negedge clk);
            ext_clk_in = ~fall;
            repeat (5) @(negedge clk);
        end
    endtask

    // Full buffer check for a state-mode run triggered at sequence index ti
    task automatic check_state_buf(input string req, input int ti, input int post);
        int d, v, r;
        for (int a = 0; a < DEPTH; a++) begin
            read_at(a, d, v);
            r = rel_of(a, ti % DEPTH, post);
            check({req, " R1 entry word"}, d, (7 * (ti + r) + 3) & 255);
            check({req, " R8 entry valid"}, v, 1);
        end
    endtask

    initial begin
        int d, v, m, ta, post, r;
        int divs [3] = '{0, 2, 5};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9: reset state
        check("R9 done after reset", int'(done), 0);
        check("R9 trig_addr after reset", int'(trig_addr), 0);
        for (int a = 0; a < DEPTH; a++) begin
            read_at(a, d, v);
            check("R9 valid after reset", v, 0);
        end

        // R2/R4/R6/R7: timing mode sweeps, full buffer wrapped before trigger
        use_cnt = 1'b1;
        mode_state = 1'b0;
        trig_ext_sel = 1'b0;
        trig_dc = '0;
        foreach (divs[j]) begin
            rate_div = DIV_W'(divs[j]);
            post = divs[j] + 3;
            post_len = AW'(post);
            m = ((divs[j] + 1) * 29 + divs[j]) & 255;
            trig_word = CH_W'(m);
            do_arm();
            wait_done("R6 timing done");
            check("R7 timing trig_addr", int'(trig_addr), 29 % DEPTH);
            ta = 29 % DEPTH;
            for (int a = 0; a < DEPTH; a++) begin
                read_at(a, d, v);
                r = rel_of(a, ta, post);
                check("R2 timing entry word", d, (m + r * (divs[j] + 1)) & 255);
                check("R8 timing entry valid", v, 1);
            end
            repeat (40) @(negedge clk);
            read_at(ta, d, v);
            check("R6 buffer frozen after done", d, m);
            check("R6 done held", int'(done), 1);
        end

        // R4/R8: all bits don't-care -> first sample triggers, rest stale
        rate_div = DIV_W'(1);
        trig_dc = 8'hFF;
        trig_word = 8'h00;
        post_len = AW'(3);
        do_arm();
        wait_done("R6 mask-all done");
        check("R4 mask-all trig_addr", int'(trig_addr), 0);
        for (int a = 0; a < DEPTH; a++) begin
            read_at(a, d, v);
            if (a <= 3) begin
                check("R1 mask-all word", d, 2 * a + 1);
                check("R8 mask-all valid", v, 1);
            end else begin
                check("R8 stale entry invalid", v, 0);
            end
        end

        // R4: partial mask, low nibble ignored
        rate_div = DIV_W'(2);
        trig_dc = 8'h0F;
        trig_word = 8'h50;
        post_len = AW'(2);
        do_arm();
        wait_done("R6 partial-mask done");
        check("R4 partial-mask trig_addr", int'(trig_addr), 26 % DEPTH);
        read_at(26 % DEPTH, d, v);
        check("R4 partial-mask trigger word", d, 80);
        read_at(25 % DEPTH, d, v);
        check("R4 partial-mask word before trigger", d, 77);

        // R3: state mode, rising then falling edge, word-match trigger
        use_cnt = 1'b0;
        mode_state = 1'b1;
        trig_dc = '0;
        trig_word = CH_W'(7 * 20 + 3);
        post_len = AW'(4);
        for (int f = 0; f < 2; f++) begin
            edge_fall = f[0];
            @(negedge clk);
            ext_clk_in = f[0];
            repeat (6) @(negedge clk);
            do_arm();
            run_ext(f[0], 40, -1);
            check("R3 state done", int'(done), 1);
            check("R3 state trig_addr", int'(trig_addr), 20 % DEPTH);
            check_state_buf("R3", 20, 4);
        end

        // R5: external trigger, match word set to an early value is ignored
        edge_fall = 1'b0;
        trig_ext_sel = 1'b1;
        trig_word = CH_W'(7 * 3 + 3);
        post_len = AW'(2);
        @(negedge clk);
        ext_clk_in = 1'b0;
        repeat (6) @(negedge clk);
        do_arm();
        run_ext(1'b0, 40, 22);
        check("R5 ext done", int'(done), 1);
        check("R5 ext trig_addr", int'(trig_addr), 22 % DEPTH);
        check_state_buf("R5", 22, 2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule